// File: doc/BRIEF.md
# Flash lock command interpreter

This block is the command front end and protection logic for the lock state of a block-erasable flash device. Software changes lock state through two bus writes. The first write is a set-up code. The second write is a confirm code that selects the operation. Three operations exist: lock one block, set the device-wide permanent lock, or clear every block lock at once. The block lock confirm carries an address inside the target block. The permanent lock confirm may use any address.

Permission depends on four things:
- the permanent lock bit;
- a write-protect input;
- a qualifier telling whether the reset pin sits at high voltage;
- a qualifier telling whether the programming supply is at or below its lockout level.

Each way an operation can fail sets its own pair of status bits. A parameterised busy interval stands in for the internal operation. During that interval the ready output is low. When the interval ends, the lock state is updated on success, or the error bits are raised on failure. Error bits stay set until software clears them.

After a lock sequence, or after the read-status command, reads return the status byte. Otherwise reads return zero, because array contents are outside this block.

Top module: `flash_lock_cui`

## Requirements
- R1: After reset, ready is 1, every block lock and the permanent lock read 0, all error bits are 0, and reads return 0x00 (array mode).
- R2: A single write never changes lock state. When the device is idle, the confirm codes 0x01, 0xF1 and 0xD0 are ignored. A lone set-up write 0x60 leaves every lock unchanged and ready at 1.
- R3: Writing 0x60 and then 0x01 with block index b in address bits [ADDR_W-1:ADDR_W-log2(NUM_BLOCKS)] sets only lock bit b. This holds when the lockout, protect and permanent-lock conditions all pass.
- R4: Writing 0x60 and then 0xF1 sets the permanent lock only when rp_hv is 1 (and vpp_low is 0). If rp_hv is 0, status bits 1 and 4 are set (0x12). Once set, the permanent lock never clears.
- R5: Writing 0x60 and then 0xD0 clears all block locks together. If the permanent lock is set, or if wp_on is 1 while rp_hv is 0, the operation fails instead: status bits 1 and 5 are set (0x22) and the locks are unchanged.
- R6: A block lock attempt fails with status bits 1 and 4 (0x12), leaving locks unchanged, in either of two cases: the permanent lock is set, or wp_on is 1 while rp_hv is 0.
- R7: When vpp_low is 1 at the confirm, every operation fails and lock state is unchanged. Set operations raise bits 3 and 4 (0x18). A clear raises bits 3 and 5 (0x28). In this case the protect bit 1 is not raised.
- R8: After 0x60, a second write that is not one of 0x01, 0xF1 or 0xD0 sets status bits 4 and 5 (0x30). It starts no operation and returns the interpreter to idle.
- R9: The confirm write's clock edge drops ready. Ready stays low for exactly BUSY_CYCLES clock cycles and then returns to 1. Status bit 7 equals ready.
- R10: The following writes put reads into status mode: 0x60, 0x70, and any write that completes a sequence. Writing 0xFF returns reads to array mode, where they return 0x00.
- R11: Error bits 1, 3, 4 and 5 accumulate (OR) across operations. Only writing 0x50 clears them.
- R12: Writes that arrive while ready is 0 are ignored. This includes a write on the same edge where the operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write cycle strobe, one command per cycle |
| wr_data | input | 8 | Command or confirm code |
| wr_addr | input | ADDR_W | Write address; upper bits select the block |
| rd_en | input | 1 | Read cycle strobe |
| rd_data | output | 8 | Status byte in status mode, 0x00 otherwise or when rd_en is 0 |
| wp_on | input | 1 | Write-protect asserted |
| rp_hv | input | 1 | Reset pin at high voltage |
| vpp_low | input | 1 | Programming voltage at or below lockout |
| ready | output | 1 | 1 when no operation is running |
| blk_locked | output | NUM_BLOCKS | Per-block lock bits |
| perm_locked | output | 1 | Permanent lock bit |

## Verification
The end of a busy interval and a new bus write can share one clock edge. On that edge the operation's result updates the lock and status state, while the write must be dropped.

The bench provokes this by holding a clear-status write on the bus for every cycle of a lock operation, including the completion edge. The sticky errors that were present before the operation must still be visible afterwards, and the new lock bit must be set.

The sweeps cover every combination of write-protect, high-voltage and lockout inputs for each block, both with and without the permanent lock. They compare status and lock outputs against an arithmetic model of the permission rules.

// File: rtl/flash_lock_pkg.sv
`timescale 1ns/1ps
package flash_lock_pkg;
  typedef enum logic [1:0] {LK_NONE, LK_BLOCK, LK_PERM, LK_CLEAR} lk_op_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_BUSY} sq_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CNF_BLOCK   = 8'h01;
  localparam logic [7:0] CNF_PERM    = 8'hF1;
  localparam logic [7:0] CNF_CLEAR   = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_RDSTAT  = 8'h70;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  localparam logic [7:0] ST_E_PROT = 8'h02;
  localparam logic [7:0] ST_E_VPP  = 8'h08;
  localparam logic [7:0] ST_E_SET  = 8'h10;
  localparam logic [7:0] ST_E_CLR  = 8'h20;
  localparam logic [7:0] ST_ERRS   = 8'h3A;
endpackage

// File: rtl/flash_lock_decode.sv
`timescale 1ns/1ps
module flash_lock_decode
  import flash_lock_pkg::*;
(
  input  logic [7:0] wr_data,
  input  logic       perm_locked,
  input  logic       wp_on,
  input  logic       rp_hv,
  input  logic       vpp_low,
  output logic       is_setup,
  output logic       is_rdstat,
  output logic       is_clrstat,
  output logic       is_array,
  output lk_op_e     cnf_op,
  output logic [7:0] fail_mask
);
  logic guarded;

  assign is_setup   = (wr_data == CMD_SETUP);
  assign is_rdstat  = (wr_data == CMD_RDSTAT);
  assign is_clrstat = (wr_data == CMD_CLRSTAT);
  assign is_array   = (wr_data == CMD_ARRAY);
  assign guarded    = perm_locked | (wp_on & ~rp_hv);

  always_comb begin
    case (wr_data)
      CNF_BLOCK: cnf_op = LK_BLOCK;
      CNF_PERM:  cnf_op = LK_PERM;
      CNF_CLEAR: cnf_op = LK_CLEAR;
      default:   cnf_op = LK_NONE;
    endcase
  end

  // Lockout voltage is judged first; protection is reported only with good supply.
  always_comb begin
    fail_mask = 8'h00;
    case (cnf_op)
      LK_BLOCK: begin
        if (vpp_low)      fail_mask = ST_E_VPP | ST_E_SET;
        else if (guarded) fail_mask = ST_E_PROT | ST_E_SET;
      end
      LK_PERM: begin
        if (vpp_low)      fail_mask = ST_E_VPP | ST_E_SET;
        else if (!rp_hv)  fail_mask = ST_E_PROT | ST_E_SET;
      end
      LK_CLEAR: begin
        if (vpp_low)      fail_mask = ST_E_VPP | ST_E_CLR;
        else if (guarded) fail_mask = ST_E_PROT | ST_E_CLR;
      end
      default: fail_mask = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_lock_seq.sv
`timescale 1ns/1ps
module flash_lock_seq
  import flash_lock_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int BLK_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             is_setup,
  input  logic             is_rdstat,
  input  logic             is_clrstat,
  input  logic             is_array,
  input  lk_op_e           cnf_op,
  input  logic [7:0]       fail_mask,
  input  logic [BLK_W-1:0] blk_in,
  output logic             busy,
  output logic             show_status,
  output logic             in_setup,
  output logic             done,
  output logic             bad_seq,
  output logic             clr_stat,
  output lk_op_e           done_op,
  output logic [7:0]       done_mask,
  output logic [BLK_W-1:0] done_blk
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;
  logic             cap_en;
  lk_op_e           op_q;
  logic [7:0]       mask_q;
  logic [BLK_W-1:0] blk_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    stat_d   = stat_q;
    cap_en   = 1'b0;
    done     = 1'b0;
    bad_seq  = 1'b0;
    clr_stat = 1'b0;
    case (state_q)
      SQ_IDLE: if (wr_en) begin
        if (is_setup) begin
          state_d = SQ_SETUP;
          stat_d  = 1'b1;
        end else if (is_rdstat) begin
          stat_d = 1'b1;
        end else if (is_array) begin
          stat_d = 1'b0;
        end else if (is_clrstat) begin
          clr_stat = 1'b1;
        end
      end
      SQ_SETUP: if (wr_en) begin
        stat_d = 1'b1;
        if (cnf_op != LK_NONE) begin
          state_d = SQ_BUSY;
          cnt_d   = CNT_W'(BUSY_CYCLES - 1);
          cap_en  = 1'b1;
        end else begin
          bad_seq = 1'b1;
          state_d = SQ_IDLE;
        end
      end
      SQ_BUSY: begin
        if (cnt_q == '0) begin
          done    = 1'b1;
          state_d = SQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= LK_NONE;
      mask_q <= 8'h00;
      blk_q  <= '0;
    end else if (cap_en) begin
      op_q   <= cnf_op;
      mask_q <= fail_mask;
      blk_q  <= blk_in;
    end
  end

  assign busy        = (state_q == SQ_BUSY);
  assign in_setup    = (state_q == SQ_SETUP);
  assign show_status = stat_q;
  assign done_op     = op_q;
  assign done_mask   = mask_q;
  assign done_blk    = blk_q;
endmodule

// File: rtl/flash_lock_store.sv
`timescale 1ns/1ps
module flash_lock_store
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done,
  input  lk_op_e                done_op,
  input  logic [7:0]            done_mask,
  input  logic [BLK_W-1:0]      done_blk,
  input  logic                  bad_seq,
  input  logic                  clr_stat,
  output logic [NUM_BLOCKS-1:0] blk_lock,
  output logic                  perm_lock,
  output logic [7:0]            err
);
  logic                  success;
  logic [NUM_BLOCKS-1:0] lock_q, lock_d;
  logic                  perm_q, perm_d;
  logic [7:0]            err_q, err_d;

  assign success = done & (done_mask == 8'h00);

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_lock
    always_comb begin
      lock_d[g] = lock_q[g];
      if (success && done_op == LK_CLEAR)
        lock_d[g] = 1'b0;
      else if (success && done_op == LK_BLOCK && done_blk == BLK_W'(g))
        lock_d[g] = 1'b1;
    end
  end

  always_comb begin
    perm_d = perm_q | (success & (done_op == LK_PERM));
    err_d  = err_q;
    if (clr_stat)     err_d = 8'h00;
    else if (bad_seq) err_d = err_q | ST_E_SET | ST_E_CLR;
    else if (done)    err_d = err_q | (done_mask & ST_ERRS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      perm_q <= 1'b0;
      err_q  <= 8'h00;
    end else begin
      lock_q <= lock_d;
      perm_q <= perm_d;
      err_q  <= err_d;
    end
  end

  assign blk_lock  = lock_q;
  assign perm_lock = perm_q;
  assign err       = err_q;
endmodule

// File: rtl/flash_lock_cui.sv
`timescale 1ns/1ps
module flash_lock_cui
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int ADDR_W      = 10,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic                  rd_en,
  output logic [7:0]            rd_data,
  input  logic                  wp_on,
  input  logic                  rp_hv,
  input  logic                  vpp_low,
  output logic                  ready,
  output logic [NUM_BLOCKS-1:0] blk_locked,
  output logic                  perm_locked
);
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int OFS_W = ADDR_W - BLK_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             is_setup, is_rdstat, is_clrstat, is_array;
  lk_op_e           cnf_op, done_op;
  logic [7:0]       fail_mask, done_mask, status_err;
  logic [BLK_W-1:0] blk_in, done_blk;
  logic             busy, show_status, in_setup, done, bad_seq, clr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign blk_in = BLK_W'(wr_addr >> OFS_W);

  flash_lock_decode u_decode (
    .wr_data     (wr_data),
    .perm_locked (perm_locked),
    .wp_on       (wp_on),
    .rp_hv       (rp_hv),
    .vpp_low     (vpp_low),
    .is_setup    (is_setup),
    .is_rdstat   (is_rdstat),
    .is_clrstat  (is_clrstat),
    .is_array    (is_array),
    .cnf_op      (cnf_op),
    .fail_mask   (fail_mask)
  );

  flash_lock_seq #(.BUSY_CYCLES(BUSY_CYCLES), .BLK_W(BLK_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .is_setup    (is_setup),
    .is_rdstat   (is_rdstat),
    .is_clrstat  (is_clrstat),
    .is_array    (is_array),
    .cnf_op      (cnf_op),
    .fail_mask   (fail_mask),
    .blk_in      (blk_in),
    .busy        (busy),
    .show_status (show_status),
    .in_setup    (in_setup),
    .done        (done),
    .bad_seq     (bad_seq),
    .clr_stat    (clr_stat),
    .done_op     (done_op),
    .done_mask   (done_mask),
    .done_blk    (done_blk)
  );

  flash_lock_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .done      (done),
    .done_op   (done_op),
    .done_mask (done_mask),
    .done_blk  (done_blk),
    .bad_seq   (bad_seq),
    .clr_stat  (clr_stat),
    .blk_lock  (blk_locked),
    .perm_lock (perm_locked),
    .err       (status_err)
  );

  assign ready   = ~busy;
  assign rd_data = (rd_en && show_status) ? ({ready, 7'b0} | status_err) : 8'h00;
endmodule

// File: rtl/flash_lock_cui_chk.sv
`timescale 1ns/1ps
module flash_lock_cui_chk #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BUSY_CYCLES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [7:0]            wr_data,
  input logic                  ready,
  input logic                  in_setup,
  input logic [NUM_BLOCKS-1:0] blk_locked,
  input logic                  perm_locked,
  input logic [7:0]            status_err
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busy_run <= 0;
    else if (!ready) begin
      if (busy_run <= BUSY_CYCLES)   busy_run <= busy_run + 1;
    end else                         busy_run <= 0;
  end

  AST_LOCK_ONLY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_locked) |-> $past(!ready));                                   // R2
  AST_PERM_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    perm_locked |=> perm_locked);                                              // R4
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= BUSY_CYCLES);                                                  // R9
  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_run == BUSY_CYCLES);                                 // R9
  AST_CLRSTAT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready && !in_setup && wr_data == flash_lock_pkg::CMD_CLRSTAT)
      |=> status_err == 8'h00);                                                // R11
  AST_ERR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(status_err));                                           // R12
endmodule

bind flash_lock_cui flash_lock_cui_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .ready       (ready),
  .in_setup    (in_setup),
  .blk_locked  (blk_locked),
  .perm_locked (perm_locked),
  .status_err  (status_err)
);

// File: tb/flash_lock_cui_bench.sv
`timescale 1ns/1ps
module flash_lock_cui_bench;
  localparam int NB = 8;
  localparam int AW = 10;
  localparam int BC = 4;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [AW-1:0] wr_addr;
  logic          rd_en;
  logic [7:0]    rd_data;
  logic          wp_on, rp_hv, vpp_low;
  logic          ready;
  logic [NB-1:0] blk_locked;
  logic          perm_locked;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [NB-1:0] exp_lock;
  logic          exp_perm;
  logic [7:0]    exp_err;

  flash_lock_cui #(.NUM_BLOCKS(NB), .ADDR_W(AW), .BUSY_CYCLES(BC)) u_flash_lock_cui (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_data(rd_data), .wp_on(wp_on), .rp_hv(rp_hv), .vpp_low(vpp_low),
    .ready(ready), .blk_locked(blk_locked), .perm_locked(perm_locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_en = 1'b1;
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_mask(input int op);
    logic guarded;
    guarded = exp_perm || (wp_on && !rp_hv);
    if (vpp_low) return (op == 2) ? 8'h28 : 8'h18;
    case (op)
      0:       return guarded ? 8'h12 : 8'h00;
      1:       return rp_hv ? 8'h00 : 8'h12;
      default: return guarded ? 8'h22 : 8'h00;
    endcase
  endfunction

  function automatic logic [AW-1:0] blk_addr(input int b, input int ofs);
    return AW'((b << (AW - $clog2(NB))) | (ofs & 7'h7F));
  endfunction

  // op: 0 block lock, 1 permanent lock, 2 clear all
  task automatic run_op(input int op, input int blk);
    logic [7:0] m, v, cnf;
    string tag;
    m = exp_mask(op);
    cnf = (op == 0) ? 8'h01 : (op == 1) ? 8'hF1 : 8'hD0;
    if (vpp_low && m != 0)  tag = "R7";
    else if (op == 0)       tag = (m == 0) ? "R3" : "R6";
    else if (op == 1)       tag = "R4";
    else                    tag = "R5";
    wr(8'h60, '0);
    wr(cnf, blk_addr(blk, 37 + blk));
    check("R9 busy after confirm", ready, 1'b0);
    rd(v);
    check("R9 status bit7 while busy", v[7], 1'b0);
    for (int k = 1; k < BC; k++) begin
      @(negedge clk);
      check("R9 busy held", ready, 1'b0);
    end
    @(negedge clk);
    check("R9 ready after interval", ready, 1'b1);
    if (m == 0) begin
      if (op == 0) exp_lock[blk] = 1'b1;
      else if (op == 1) exp_perm = 1'b1;
      else exp_lock = '0;
    end else begin
      exp_err |= m;
    end
    rd(v);
    check({tag, " status"}, v, 8'h80 | exp_err);
    check({tag, " locks"}, blk_locked, exp_lock);
    check({tag, " perm"}, perm_locked, exp_perm);
  endtask

  task automatic clr_status();
    wr(8'h50, '0);
    exp_err = 8'h00;
  endtask

  task automatic good_clear();
    wp_on = 1'b0; rp_hv = 1'b0; vpp_low = 1'b0;
    clr_status();
    run_op(2, 0);
    clr_status();
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; wr_addr = '0; rd_en = 1'b0;
    wp_on = 1'b0; rp_hv = 1'b0; vpp_low = 1'b0;
    exp_lock = '0; exp_perm = 1'b0; exp_err = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 ready", ready, 1'b1);
    check("R1 locks", blk_locked, '0);
    check("R1 perm", perm_locked, 1'b0);
    rd(v);
    check("R1 array read", v, 8'h00);

    // R10 mode switching
    wr(8'h70, '0);
    rd(v);
    check("R10 read status", v, 8'h80);
    wr(8'hFF, '0);
    rd(v);
    check("R10 back to array", v, 8'h00);

    // R2 lone confirms and lone set-up
    wr(8'h01, blk_addr(3, 0));
    wr(8'hF1, '0);
    wr(8'hD0, '0);
    check("R2 lone confirms locks", blk_locked, '0);
    check("R2 lone confirms perm", perm_locked, 1'b0);
    check("R2 lone confirms ready", ready, 1'b1);
    wr(8'h60, '0);
    check("R2 lone setup locks", blk_locked, '0);
    check("R2 lone setup ready", ready, 1'b1);
    rd(v);
    check("R10 status after setup", v, 8'h80);

    // R8 invalid confirm
    wr(8'h70, '0);
    exp_err |= 8'h30;
    rd(v);
    check("R8 invalid confirm status", v, 8'h80 | exp_err);
    check("R8 ready", ready, 1'b1);
    check("R8 locks", blk_locked, '0);
    wr(8'h60, '0);
    wr(8'hFF, '0);
    rd(v);
    check("R8 invalid confirm 0xFF", v, 8'hB0);
    clr_status();

    // Sweep: every pin combination, every block, without permanent lock
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < NB; b++) begin
        wp_on = c[0]; rp_hv = c[1]; vpp_low = c[2];
        clr_status();
        run_op(0, b);
      end
      clr_status();
      run_op(2, 0);
      if (exp_lock != '0) good_clear();
    end

    // R12 and completion-edge write: sticky error present, write 0x50 through busy
    wp_on = 1'b0; rp_hv = 1'b0; vpp_low = 1'b1;
    clr_status();
    run_op(0, 2);
    vpp_low = 1'b0;
    wr(8'h60, '0);
    wr(8'h01, blk_addr(5, 9));
    wr_en = 1'b1; wr_data = 8'h50;
    repeat (BC) @(negedge clk);
    wr_en = 1'b0;
    exp_lock[5] = 1'b1;
    check("R12 ready after busy", ready, 1'b1);
    rd(v);
    check("R12 clear-status ignored while busy", v, 8'h80 | exp_err);
    check("R12 lock applied", blk_locked, exp_lock);

    // R11 accumulation
    vpp_low = 1'b1;
    run_op(2, 0);
    vpp_low = 1'b0;
    wr(8'h60, '0);
    wr(8'h50, '0);
    exp_err |= 8'h30;
    rd(v);
    check("R11 accumulated", v, 8'h80 | exp_err);
    run_op(1, 0);
    wr(8'h50, '0);
    exp_err = 8'h00;
    rd(v);
    check("R11 cleared", v, 8'h80);
    good_clear();

    // Permanent lock: every failing combination, then success
    for (int c = 0; c < 8; c++) begin
      wp_on = c[0]; rp_hv = c[1]; vpp_low = c[2];
      if (!(rp_hv && !vpp_low)) begin
        clr_status();
        run_op(1, c);
      end
    end
    wp_on = 1'b1; rp_hv = 1'b1; vpp_low = 1'b0;
    clr_status();
    run_op(1, 6);
    check("R4 perm set", perm_locked, 1'b1);

    // Sweep with permanent lock set: everything refused
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < NB; b++) begin
        wp_on = c[0]; rp_hv = c[1]; vpp_low = c[2];
        clr_status();
        run_op(0, b);
      end
      clr_status();
      run_op(2, 0);
    end
    check("R4 perm remains", perm_locked, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule